// File: doc/BRIEF.md
# Scanline-Period Interrupt Timer

This block raises a level interrupt request after a programmable number of emulated video scanlines have passed. Time is measured in CPU clock cycles: a signed prescaler models a line of 341 dot periods that drains by 3 dots on every CPU cycle tick. Each time a line's worth of dots is used up, an 8-bit up-counter advances. The request is raised when that counter rolls over from 0xFF to 0x00.

Software programs the block through plain CPU register writes. An 8-bit start value is written as two 4-bit halves. A control write arms or disarms the timer and drops any outstanding request. A separate acknowledge write drops the request and leaves everything else alone. Once armed, the counter starts from the start value and keeps counting past the rollover without reloading. The next request therefore comes a full 256 lines after the first. Bank mapping and the rest of the cartridge logic sit outside this block.

Top module: `scanline_irq_timer`

## Requirements
- R1: Register writes are decoded on `wr_addr & 16'hF003`. Code 0xF000 loads start-value bits 3:0 from `wr_data[3:0]` and code 0xF002 loads start-value bits 7:4 from `wr_data[3:0]`. Each of these writes keeps the other half, and `wr_data[7:4]` is ignored.
- R2: A write to code 0xF001 sets the armed flag from `wr_data[1]` and always clears the pending request.
- R3: When a 0xF001 write arms the timer, the prescaler is set to 341 and the counter is loaded from the start value.
- R4: A write to code 0xF003 clears the pending request and changes no other state.
- R5: While armed, each cycle with `cycle_tick` high subtracts 3 from the prescaler. When the result is 0 or below, 341 is added to it and the counter increments. From arming, the k-th increment therefore falls on tick ceil(341*k/3).
- R6: An increment from 0xFF to 0x00 sets the pending request. The counter then continues from 0x00 without reloading.
- R7: While disarmed, ticks change neither the prescaler, the counter nor the pending request, so `irq` stays low.
- R8: `irq` is high exactly while the request is pending. It stays high until a 0xF003 write, a 0xF001 write or reset.
- R9: Reset (`rst_n` low) clears the start value, counter, prescaler, armed flag and pending request, so `irq` is low.
- R10: With a start value of 0xFF, `irq` rises on the 114th tick after arming. With 0xFE, it is still low after 115 ticks.
- R11: A tick that arrives in the same cycle as a 0xF001 write is discarded. A rollover in the same cycle as a 0xF003 write leaves the request pending.
- R12: Writes whose decoded code is none of 0xF000 to 0xF003 have no effect. Aliases that decode to one of those codes act like it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU register write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cycle_tick | input | 1 | One CPU cycle has elapsed |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that each write strobe and each tick lasts exactly one clock. They also assume that the prescaler is entered only through reset or an arming write, so that it never leaves the range -2 to 341. The bench respects both conditions: it drives every input for one cycle at a time from a falling clock edge. It mixes random write codes, aliases, unmapped addresses and ticks that coincide with writes. Start values are biased toward the top of the range so that rollovers occur often within the run.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  localparam logic [15:0] REG_MASK = 16'hF003;
  localparam logic [15:0] REG_RLO  = 16'hF000;
  localparam logic [15:0] REG_CTRL = 16'hF001;
  localparam logic [15:0] REG_RHI  = 16'hF002;
  localparam logic [15:0] REG_ACK  = 16'hF003;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RLO,
    OP_RHI,
    OP_CTRL,
    OP_ACK
  } reg_op_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output reg_op_e           op,
  output logic              en_bit,
  output logic [CNT_W-1:0]  reload_q
);
  localparam int NIB_W = CNT_W / 2;

  logic [ADDR_W-1:0] code;
  logic [NIB_W-1:0]  nib;

  function automatic logic [CNT_W-1:0] merge_half(
    input logic [CNT_W-1:0] old, input logic [NIB_W-1:0] half, input logic upper);
    logic [CNT_W-1:0] r;
    r = old;
    if (upper) r[CNT_W-1:NIB_W] = half;
    else       r[NIB_W-1:0]     = half;
    return r;
  endfunction

  assign code   = wr_addr & ADDR_W'(REG_MASK);
  assign nib    = NIB_W'(wr_data);
  assign en_bit = wr_data[EN_BIT];

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if      (code == ADDR_W'(REG_RLO))  op = OP_RLO;
      else if (code == ADDR_W'(REG_RHI))  op = OP_RHI;
      else if (code == ADDR_W'(REG_CTRL)) op = OP_CTRL;
      else if (code == ADDR_W'(REG_ACK))  op = OP_ACK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             reload_q <= '0;
    else if (op == OP_RLO)  reload_q <= merge_half(reload_q, nib, 1'b0);
    else if (op == OP_RHI)  reload_q <= merge_half(reload_q, nib, 1'b1);
  end

  assert_keep_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RLO) |=> (reload_q[CNT_W-1:NIB_W] == $past(reload_q[CNT_W-1:NIB_W]))
                       && (reload_q[NIB_W-1:0] == $past(nib)));
  assert_keep_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RHI) |=> (reload_q[NIB_W-1:0] == $past(reload_q[NIB_W-1:0]))
                       && (reload_q[CNT_W-1:NIB_W] == $past(nib)));
  assert_no_stray_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_RLO && op != OP_RHI) |=> $stable(reload_q));
endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
  parameter int PRESC_W       = 10,
  parameter int LINE_DOTS     = 341,
  parameter int DOTS_PER_TICK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic line_evt
);
  typedef logic signed [PRESC_W-1:0] presc_t;

  function automatic presc_t drain(input presc_t p);
    return p - presc_t'(DOTS_PER_TICK);
  endfunction

  function automatic logic spent(input presc_t d);
    return d <= presc_t'(0);
  endfunction

  function automatic presc_t refill(input presc_t d);
    return d + presc_t'(LINE_DOTS);
  endfunction

  presc_t presc_q;
  presc_t drained;

  assign drained  = drain(presc_q);
  assign line_evt = run && spent(drained);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc_q <= '0;
    else if (load)     presc_q <= presc_t'(LINE_DOTS);
    else if (run)      presc_q <= spent(drained) ? refill(drained) : drained;
  end

  assert_presc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_q > -presc_t'(DOTS_PER_TICK)) && (presc_q <= presc_t'(LINE_DOTS)));
  assert_refill_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt |=> (presc_q > presc_t'(0)));
  assert_idle_presc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(presc_q));
  assert_arm_presc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (presc_q == presc_t'(LINE_DOTS)));
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             wrap_evt
);
  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign wrap_evt = step && (count_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (load)  count_q <= load_val;
    else if (step)  count_q <= bump(count_q);
  end

  assert_arm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count_q == '0));
  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(count_q));
endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 8,
  parameter int PRESC_W       = 10,
  parameter int LINE_DOTS     = 341,
  parameter int DOTS_PER_TICK = 3,
  parameter int EN_BIT        = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cycle_tick,
  output logic              irq
);
  reg_op_e          op;
  logic             en_bit;
  logic [CNT_W-1:0] reload_q;
  logic             ctrl_wr, ack_wr, arm_load, run, line_evt, wrap_evt;
  logic             armed_q, pend_q;

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT))
    u_decode (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
              .wr_data(wr_data), .op(op), .en_bit(en_bit), .reload_q(reload_q));

  assign ctrl_wr  = (op == OP_CTRL);
  assign ack_wr   = (op == OP_ACK);
  assign arm_load = ctrl_wr && en_bit;
  assign run      = armed_q && cycle_tick && !ctrl_wr;

  irq_prescaler #(.PRESC_W(PRESC_W), .LINE_DOTS(LINE_DOTS), .DOTS_PER_TICK(DOTS_PER_TICK))
    u_presc (.clk(clk), .rst_n(rst_n), .load(arm_load), .run(run), .line_evt(line_evt));

  irq_line_counter #(.CNT_W(CNT_W))
    u_count (.clk(clk), .rst_n(rst_n), .load(arm_load), .load_val(reload_q),
             .step(line_evt), .wrap_evt(wrap_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (ctrl_wr)  armed_q <= en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (wrap_evt)           pend_q <= 1'b1;
    else if (ctrl_wr || ack_wr)  pend_q <= 1'b0;
  end

  assign irq = pend_q;

  assert_ctrl_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !irq);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !wrap_evt) |=> !irq);
  assert_rise_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(wrap_evt));
  assert_hold_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr && !ctrl_wr) |=> irq);
  assert_disarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !line_evt);
  assert_tick_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> !line_evt);
endmodule

// File: tb/test_scanline_irq_timer.sv
`timescale 1ns/1ps
module test_scanline_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cycle_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_reload, m_cnt, m_presc;
  bit m_en, m_pend;

  always #2.5 clk = ~clk;

  scanline_irq_timer i_scanline_irq_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cycle_tick(cycle_tick), .irq(irq));

  // ticks needed from arming until k increments: ceil(341*k/3)
  function automatic int ticks_for(input int k);
    return (341 * k + 2) / 3;
  endfunction

  // Reference model, updated on the same edge the design samples its inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reload = 0; m_cnt = 0; m_presc = 0; m_en = 0; m_pend = 0;
    end else begin
      bit ctrl_hit, ack_hit, wrapped;
      int code, left;
      ctrl_hit = 0; ack_hit = 0; wrapped = 0;
      code = int'(wr_addr) & 'hF003;
      if (wr_en) begin
        if (code == 'hF000) m_reload = (m_reload & 'hF0) | (int'(wr_data) & 'h0F);
        else if (code == 'hF002) m_reload = (m_reload & 'h0F) | ((int'(wr_data) & 'h0F) * 16);
        else if (code == 'hF001) begin
          ctrl_hit = 1;
          m_en = wr_data[1];
          m_pend = 0;
          if (m_en) begin m_presc = 341; m_cnt = m_reload; end
        end else if (code == 'hF003) ack_hit = 1;
      end
      if (m_en && cycle_tick && !ctrl_hit) begin
        left = m_presc - 3;
        if (left < 1) begin
          m_presc = left + 341;
          m_cnt = (m_cnt + 1) % 256;
          wrapped = (m_cnt == 0);
        end else m_presc = left;
      end
      if (wrapped) m_pend = 1;
      else if (ack_hit) m_pend = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison of the request line against the model
  always @(negedge clk) begin
    if (rst_n && !done) check(irq === m_pend, "R8 level", int'(irq), int'(m_pend));
  end

  task automatic cyc(input bit w, input logic [15:0] a, input logic [7:0] d, input bit t);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; cycle_tick = t;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b1);
  endtask

  task automatic settle();
    @(negedge clk);
    wr_en = 0; cycle_tick = 0;
  endtask

  task automatic expect_irq(input bit exp, input string tag);
    check(irq === exp, tag, int'(irq), int'(exp));
  endtask

  task automatic arm(input logic [7:0] start);
    wr(16'hF000, {4'h0, start[3:0]});
    wr(16'hF002, {4'h0, start[7:4]});
    wr(16'hF001, 8'h02);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    expect_irq(1'b0, "R9 reset low");
    rst_n = 1'b1;
    settle();
    expect_irq(1'b0, "R9 after reset");

    // R10 start 0xFF: rises on tick 114
    arm(8'hFF);
    ticks(113); settle(); expect_irq(1'b0, "R10 FF before 114");
    ticks(1);   settle(); expect_irq(1'b1, "R10 FF at 114");
    // R8 held without ticks, R4 acknowledge drops it
    repeat (10) settle();
    expect_irq(1'b1, "R8 held");
    wr(16'hF003, 8'h00); settle(); expect_irq(1'b0, "R4 ack");

    // R10 start 0xFE: low after 115, R5 second increment on tick 228
    wr(16'hF000, 8'h0E); wr(16'hF001, 8'h02);
    ticks(115); settle(); expect_irq(1'b0, "R10 FE after 115");
    ticks(ticks_for(2) - 116); settle(); expect_irq(1'b0, "R5 before 2nd step");
    ticks(1); settle(); expect_irq(1'b1, "R5 2nd step wraps");

    // R2 disarm clears; R7 ticks while disarmed do nothing
    wr(16'hF001, 8'h00); settle(); expect_irq(1'b0, "R2 ctrl clears");
    ticks(500); settle(); expect_irq(1'b0, "R7 disarmed");

    // R1 halves with ignored data bits: start becomes 0xF3
    wr(16'hF002, 8'hAF); wr(16'hF000, 8'h53);
    // R12 unmapped write does not arm; alias of 0xF001 does
    wr(16'hE001, 8'h02);
    ticks(300); settle(); expect_irq(1'b0, "R12 unmapped ignored");
    wr(16'hF00D, 8'h02);
    ticks(ticks_for(13) - 1); settle(); expect_irq(1'b0, "R1 start F3 early");
    ticks(1); settle(); expect_irq(1'b1, "R1 start F3 wrap");

    // R11 tick with arming write is discarded
    wr(16'hF000, 8'h0F); wr(16'hF002, 8'h0F); wr(16'hF001, 8'h02);
    ticks(113);
    cyc(1'b1, 16'hF001, 8'h02, 1'b1);
    ticks(113); settle(); expect_irq(1'b0, "R11 tick dropped on arm");
    ticks(1);   settle(); expect_irq(1'b1, "R11 rearm wraps at 114");
    // R11 rollover wins over acknowledge
    arm(8'hFF);
    ticks(113);
    cyc(1'b1, 16'hF003, 8'h00, 1'b1);
    settle(); expect_irq(1'b1, "R11 wrap beats ack");

    // R6 no reload: next request a full 256 increments later
    arm(8'hFF);
    ticks(114); settle(); expect_irq(1'b1, "R6 first wrap");
    wr(16'hF003, 8'h00);
    ticks(ticks_for(257) - ticks_for(1) - 1); settle();
    expect_irq(1'b0, "R6 before second wrap");
    ticks(1); settle(); expect_irq(1'b1, "R6 second wrap");
    wr(16'hF001, 8'h00);

    // Random phase, high start values favoured
    for (int n = 0; n < 40000; n++) begin
      int r;
      logic [7:0] d;
      bit t;
      r = int'($urandom % 32);
      d = 8'($urandom);
      t = ($urandom % 4) != 0;
      if (r < 2)       cyc(1'b1, 16'hF002, {d[7:4], 3'b111, d[0]}, t);
      else if (r < 4)  cyc(1'b1, 16'hF000, d, t);
      else if (r == 4) cyc(1'b1, 16'hF001 | {4'h0, 4'($urandom), 8'h0},
                           ((($urandom % 4) == 0) ? 8'h00 : 8'h02) | (d & 8'hFD), t);
      else if (r == 5) cyc(1'b1, 16'hF003, d, t);
      else if (r == 6) cyc(1'b1, 16'($urandom), d, t);
      else             cyc(1'b0, 16'h0, 8'h0, t);
    end
    settle();
    expect_irq(m_pend, "R8 random end");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule